// File: doc/BRIEF.md
# Serial Codec Register Write Engine

This block writes one control register in one of two codec chips over a three-wire serial link. The link has a shared clock line, a shared data line and one active-low select per chip. A requester hands over a chip index, a 5-bit register address and a data byte. The engine then produces a slow, software-paced wire sequence from these values and raises a completion pulse when the link has returned to idle.

The frame is 16 bits long and is sent most significant bit first. The upper byte is `0xA0 | addr`: bits 15:14 carry the fixed device address `2'b10`, bit 13 is the write flag (always 1), and bits 12:8 carry the register address. The lower byte is the data. Every step on the wire is held for `SETTLE_CYC` system clocks. A transfer therefore runs through 51 equal phases, in this order:

1. idle lines held high;
2. the select is driven low;
3. for each of the 16 bits, three phases: clock low, data presented, clock high;
4. all lines returned high.

The request port uses valid/ready. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a transfer runs, `req_ready` stays low, so the requester must hold its request or retry later. Nothing is buffered.

Top module: `codec_wr_engine`

## Requirements
- R1: After synchronous active-high reset, `sclk`, `sdata` and both bits of `cs_n` are 1, `busy` and `done` are 0, and `req_ready` is 1.
- R2: Each accepted request sends exactly 16 bits, MSB first, sampled on the rising edge of `sclk`. The bits are `{2'b10, 1'b1, addr[4:0], data[7:0]}`.
- R3: A chip index of 0 drives `cs_n[0]` low. An index of 1, 2 or 3 drives `cs_n[1]` low. The other select stays high, and both selects are never low together.
- R4: While a select is low, `sdata` changes only while `sclk` is low. Each bit is sent as clock low, then data, then clock high.
- R5: Every wire phase lasts exactly `SETTLE_CYC` clocks, so `busy` stays high for exactly 51 × `SETTLE_CYC` clocks per transfer.
- R6: Before a select falls, `sclk` and `sdata` are high. After the last bit, `sclk`, `sdata` and both selects all return high together.
- R7: A request whose chip index is greater than 3 is consumed without effect: `busy` stays low, no select falls and `done` does not pulse.
- R8: `busy` rises on the edge that accepts a valid request. `req_ready` is low while `busy` is high, and requests presented then are not taken.
- R9: `done` is a single-clock pulse, asserted in the first cycle in which `busy` is low after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_chip | input | IDX_W | Target chip index (0..3 valid) |
| req_addr | input | 5 | Codec register address |
| req_data | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, idles high |
| cs_n | output | 2 | Active-low chip selects |

## Verification
The bench sends frames to chip indices 0, 1, 2 and 3 with address and data patterns of alternating bits, all zeros, all ones and mixed nibbles. This separates errors in bit order, in the fixed header bits and in select steering. An index of 5 shows that out-of-range requests leave the link untouched. Holding a second request while the engine is busy shows that it is never taken. The length of each busy window, compared against 51 phases, catches a phase that is dropped, repeated or mistimed.

// File: rtl/codec_wr_pkg.sv
package codec_wr_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PREP,
    PH_SEL,
    PH_CLKLO,
    PH_DATA,
    PH_CLKHI,
    PH_FINISH
  } phase_t;
endpackage

// File: rtl/codec_frame_pack.sv
module codec_frame_pack #(
  parameter logic [1:0] DEV_ADDR = 2'b10
) (
  input  logic [codec_wr_pkg::ADDR_W-1:0]  reg_addr,
  input  logic [codec_wr_pkg::DATA_W-1:0]  reg_data,
  output logic [codec_wr_pkg::FRAME_W-1:0] frame
);
  // header: device address, write flag, register address; then payload
  always_comb frame = {DEV_ADDR, 1'b1, reg_addr, reg_data};
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST) else $error("timer overran its limit"); // R5
endmodule

// File: rtl/codec_wr_engine.sv
module codec_wr_engine #(
  parameter int SETTLE_CYC = 10000,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_chip,
  input  logic [4:0]       req_addr,
  input  logic [7:0]       req_data,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             sdata,
  output logic [1:0]       cs_n
);
  import codec_wr_pkg::*;

  localparam int BW = $clog2(FRAME_W);

  phase_t               phase;
  logic [FRAME_W-1:0]   frame_q;
  logic [FRAME_W-1:0]   frame_d;
  logic [BW-1:0]        bit_idx;
  logic                 sel_hi;
  logic                 step_done;
  logic                 accept;
  logic                 in_range;

  codec_frame_pack #(.DEV_ADDR(2'b10)) u_pack (
    .reg_addr (req_addr),
    .reg_data (req_data),
    .frame    (frame_d)
  );

  settle_timer #(.LIMIT(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (phase != PH_IDLE),
    .expire (step_done)
  );

  assign req_ready = (phase == PH_IDLE);
  assign busy      = (phase != PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_range  = (32'(req_chip) <= 32'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      frame_q <= '0;
      bit_idx <= BW'(FRAME_W - 1);
      sel_hi  <= 1'b0;
      sclk    <= 1'b1;
      sdata   <= 1'b1;
      cs_n    <= 2'b11;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept && in_range) begin
            frame_q <= frame_d;
            sel_hi  <= |req_chip;
            bit_idx <= BW'(FRAME_W - 1);
            phase   <= PH_PREP;
          end
        end
        PH_PREP: if (step_done) begin
          cs_n  <= sel_hi ? 2'b01 : 2'b10;
          phase <= PH_SEL;
        end
        PH_SEL: if (step_done) begin
          sclk  <= 1'b0;
          phase <= PH_CLKLO;
        end
        PH_CLKLO: if (step_done) begin
          sdata <= frame_q[bit_idx];
          phase <= PH_DATA;
        end
        PH_DATA: if (step_done) begin
          sclk  <= 1'b1;
          phase <= PH_CLKHI;
        end
        PH_CLKHI: if (step_done) begin
          if (bit_idx == '0) begin
            sclk  <= 1'b1;
            sdata <= 1'b1;
            cs_n  <= 2'b11;
            phase <= PH_FINISH;
          end else begin
            bit_idx <= bit_idx - 1'b1;
            sclk    <= 1'b0;
            phase   <= PH_CLKLO;
          end
        end
        PH_FINISH: if (step_done) begin
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_DATA_STABLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk) && cs_n != 2'b11) |-> $stable(sdata))
    else $error("data moved while clock high"); // R4
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1) else $error("both selects low"); // R3
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk && sdata && cs_n == 2'b11)) else $error("lines not idle"); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one clock"); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!busy && $past(busy))) else $error("done not at busy fall"); // R9
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (accept && in_range) |=> busy) else $error("busy not raised"); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_range) |=> !busy) else $error("bad index started"); // R7
endmodule

// File: tb/codec_wr_engine_tb_top.sv
module codec_wr_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S          = 3;
  localparam int PHASES     = 51;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_chip = '0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic       busy, done, sclk, sdata;
  logic [1:0] cs_n;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int frames_sent = 0;

  typedef struct { int line; logic [15:0] frame; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_wr_engine #(.SETTLE_CYC(S), .IDX_W(3)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chip(req_chip), .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .cs_n(cs_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor state
  logic        p_sclk = 1'b1, p_sdata = 1'b1, p_done = 1'b0, p_busy = 1'b0;
  logic [1:0]  p_cs = 2'b11;
  logic [15:0] shreg = '0;
  int          nbits = 0;
  int          line  = -1;
  int          busy_len = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n != 2'b11 && p_cs == 2'b11) begin
        // R6: lines high before select falls
        check(sclk && sdata, "R6", "lines before select", {sclk, sdata}, 2'b11);
        line  = (cs_n == 2'b10) ? 0 : 1;
        nbits = 0;
      end
      if (cs_n != 2'b11 && sclk && !p_sclk) begin
        shreg = {shreg[14:0], sdata};
        nbits++;
      end
      if (cs_n != 2'b11 && sclk && p_sclk && sdata != p_sdata)
        check(0, "R4", "data change with clock high", sdata, p_sdata);
      if (cs_n == 2'b11 && p_cs != 2'b11) begin
        exp_t e;
        check(sclk && sdata, "R6", "lines after last bit", {sclk, sdata}, 2'b11);
        check(nbits == 16, "R2", "bit count", nbits, 16);
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected frame", shreg, 0);
        end else begin
          e = exp_q.pop_front();
          check(shreg == e.frame, "R2", "frame content", shreg, e.frame);
          check(line == e.line, "R3", "select line", line, e.line);
        end
      end
      if (busy) busy_len++;
      if (!busy && p_busy) begin
        check(busy_len == PHASES*S, "R5", "busy length", busy_len, PHASES*S);
        check(done, "R9", "done at busy fall", done, 1);
        busy_len = 0;
      end
      if (done) done_cnt++;
      if (done && p_done) check(0, "R9", "done width", 2, 1);
      p_sclk = sclk; p_sdata = sdata; p_cs = cs_n; p_done = done; p_busy = busy;
    end
  end

  task automatic send(input int chip, input logic [4:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chip = chip[2:0]; req_addr = a; req_data = d;
    if (chip <= 3) begin
      e.line  = (chip == 0) ? 0 : 1;
      e.frame = {8'hA0 | {3'b000, a}, d};
      exp_q.push_back(e);
      frames_sent++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (chip <= 3) check(busy, "R8", "busy after accept", busy, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(sclk && sdata, "R1", "clock/data idle", {sclk, sdata}, 2'b11);
    check(cs_n == 2'b11, "R1", "selects idle", cs_n, 2'b11);
    check(!busy && !done, "R1", "busy/done low", {busy, done}, 0);
    check(req_ready, "R1", "ready high", req_ready, 1);

    send(0, 5'h03, 8'hA5); wait_idle();
    send(1, 5'h1F, 8'h00); wait_idle();
    send(2, 5'h10, 8'hFF); wait_idle();
    send(3, 5'h00, 8'h5A); wait_idle();

    // R7: out-of-range index
    send(5, 5'h0A, 8'h3C);
    for (int i = 0; i < 4*S; i++) begin
      check(!busy && cs_n == 2'b11, "R7", "no activity on bad index",
            {busy, cs_n}, 3'b011);
      @(negedge clk);
    end

    // R8: request while busy is ignored
    send(1, 5'h15, 8'hC3);
    req_valid = 1'b1; req_chip = 3'd0; req_addr = 5'h01; req_data = 8'h11;
    for (int i = 0; i < 5; i++) begin
      check(!req_ready, "R8", "ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_idle();

    check(exp_q.size() == 0, "R2", "frames outstanding", exp_q.size(), 0);
    check(done_cnt == frames_sent, "R9", "done pulse count", done_cnt, frames_sent);
    finish_run();
  end
endmodule